// File: doc/BRIEF.md
# Last-Number Redial Buffer Controller

This block keeps the most recent number a telephone dialer has dialed and replays it on request. It receives decoded key events one at a time and classifies each. A key can be a digit, a pause, a redial request, a hook flash, a change of signalling mode, or a test entry. Storable events go into a small circular store. When the shared pause/redial key acts as redial, the stored entries stream out, oldest first, to the signalling sequencer.

The key input and the playback output are valid/ready streams. The key input drops `key_ready` while a flash is pending, while a redial waits or plays, and while the line is on-hook or has just gone off-hook. A key held on `key_valid` simply waits. The playback output obeys normal back-pressure. Once `play_valid` is high, it and `play_entry` hold steady until `play_ready` is seen high at a clock edge. Then the next entry follows in the next cycle.

Hook state, the default signalling mode, the flash-complete acknowledge and the dialing-idle flag are plain level inputs. `busy` and `tone_mode` are plain level outputs. The store keeps its contents while the line is on-hook. `DEPTH` must be a power of two.

Top module: `lnr_ctrl`

Key codes on `key_code`:
- 0-9: digits
- 10: star
- 11: hash
- 12: pause/redial
- 13: flash
- 14: switch to tone
- 15: switch to pulse
- 16: single-tone test
- 17-31: unused

Stored entry codes on `play_entry`:
- 0-9: digits
- 10: star
- 11: hash
- 12: pause
- 13: mode-change marker

## Requirements
- R1: The store holds `DEPTH` (32) entries. Once more than 32 entries are written, each new entry replaces the oldest one, and a redial returns exactly the last min(N,32) entries written.
- R2: Key 12 is a redial request while the controller is "fresh", which it is right after going off-hook or after a flash. Otherwise key 12 stores a pause entry (code 12).
- R3: When the controller is fresh, the next storable entry first empties the store and then becomes its only entry. Flash keys and redial requests store nothing and leave the contents intact.
- R4: A rising `off_hook` makes the controller fresh and loads `tone_mode` from `mode_default` (1 = tone, 0 = pulse). Keys are refused in the first off-hook cycle.
- R5: After an accepted flash key, `busy` stays high and `key_ready` stays low until `flash_done` is seen.
- R6: Playback presents the stored entries oldest first, one per `play_valid`/`play_ready` handshake. `busy` is high from the redial request to the final handshake.
- R7: Key 14 in pulse mode stores a marker (code 13) and selects tone mode. In tone mode key 14 does nothing. Key 15 selects pulse mode and stores nothing.
- R8: Key 10 in pulse mode stores a marker and selects tone mode. Key 10 in tone mode stores a star (code 10). When a marker is handed out during playback, tone mode is selected.
- R9: Key 16 and keys 17-31 are accepted and have no effect on the store or the mode.
- R10: While `off_hook` is low, `key_ready`, `play_valid` and `busy` go low within one cycle, and any playback in progress is aborted. The stored contents are kept.
- R11: Playback starts only once `dial_idle` is high. A redial request with an empty store produces no playback and leaves `busy` low.
- R12: While `play_valid` is high and `play_ready` is low, `play_valid` and `play_entry` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| off_hook | input | 1 | 1 = off-hook, 0 = on-hook |
| mode_default | input | 1 | Mode loaded on going off-hook (1 = tone) |
| key_valid | input | 1 | Key event offered |
| key_ready | output | 1 | Key event can be accepted |
| key_code | input | 5 | Key event code |
| flash_done | input | 1 | Sequencer finished the hook flash |
| dial_idle | input | 1 | Sequencer has no signalling in progress |
| play_valid | output | 1 | Playback entry offered |
| play_ready | input | 1 | Sequencer takes the playback entry |
| play_entry | output | 5 | Playback entry code |
| busy | output | 1 | Flash pending, redial waiting or playing |
| tone_mode | output | 1 | Current signalling mode (1 = tone) |

## Verification
The main sweep dials every count of entries from 0 to 40 across hook cycles and redials each time. This separates the empty, partly filled, exactly full and wrapped stores, and shows whether the oldest entries are dropped in the right order. Mixed sequences of digits, pauses and flashes show whether key 12 chooses pause or redial correctly, and whether a flash keeps the old number or clears it depending on what follows. Mode sequences of star, the two mode-switch keys and redial in pulse mode show whether a marker is recorded only for pulse-to-tone changes and whether it is replayed. The playback sink stalls on a fixed pattern throughout, and separate runs hold `dial_idle` low and go on-hook mid-playback.

// File: rtl/lnr_pkg.sv
package lnr_pkg;
  localparam int KEY_WIDTH = 5;
  localparam int ENT_WIDTH = 5;

  localparam int C_STAR   = 10;
  localparam int C_HASH   = 11;
  localparam int C_PR     = 12;
  localparam int C_FLASH  = 13;
  localparam int C_TONE   = 14;
  localparam int C_PULSE  = 15;

  localparam int E_PAUSE  = 12;
  localparam int E_MARK   = 13;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_STORE,
    ACT_REDIAL,
    ACT_FLASH,
    ACT_PULSE
  } act_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_FLASH,
    PH_WAIT,
    PH_PLAY
  } phase_e;
endpackage

// File: rtl/lnr_key_decode.sv
module lnr_key_decode
  import lnr_pkg::*;
#(
  parameter int KEY_W = KEY_WIDTH,
  parameter int ENT_W = ENT_WIDTH
) (
  input  logic [KEY_W-1:0] code,
  input  logic             tone,
  input  logic             fresh,
  output act_e             act,
  output logic [ENT_W-1:0] entry,
  output logic             to_tone
);
  always_comb begin
    act     = ACT_NONE;
    entry   = '0;
    to_tone = 1'b0;
    if (code <= KEY_W'(9) || code == KEY_W'(C_HASH)) begin
      act   = ACT_STORE;
      entry = ENT_W'(code);
    end else if (code == KEY_W'(C_STAR)) begin
      act = ACT_STORE;
      if (tone) begin
        entry = ENT_W'(C_STAR);
      end else begin
        entry   = ENT_W'(E_MARK);
        to_tone = 1'b1;
      end
    end else if (code == KEY_W'(C_PR)) begin
      if (fresh) begin
        act = ACT_REDIAL;
      end else begin
        act   = ACT_STORE;
        entry = ENT_W'(E_PAUSE);
      end
    end else if (code == KEY_W'(C_FLASH)) begin
      act = ACT_FLASH;
    end else if (code == KEY_W'(C_TONE)) begin
      if (!tone) begin
        act     = ACT_STORE;
        entry   = ENT_W'(E_MARK);
        to_tone = 1'b1;
      end
    end else if (code == KEY_W'(C_PULSE)) begin
      act = ACT_PULSE;
    end
  end
endmodule

// File: rtl/lnr_ring.sv
module lnr_ring #(
  parameter int DEPTH = 32,
  parameter int ENT_W = 5,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_restart,
  input  logic [ENT_W-1:0] wr_data,
  input  logic [PW-1:0]    rd_off,
  output logic [ENT_W-1:0] rd_data,
  output logic [LW-1:0]    fill
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr;
  logic [PW-1:0]    waddr;
  logic [PW-1:0]    base;
  logic [PW-1:0]    raddr;

  assign waddr = wr_restart ? '0 : wptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      fill <= '0;
    end else if (wr_en) begin
      wptr <= waddr + 1'b1;
      if (wr_restart) begin
        fill <= LW'(1);
      end else if (fill != LW'(DEPTH)) begin
        fill <= fill + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[waddr] <= wr_data;
    end
  end

  // Oldest entry sits fill places behind the write pointer (power-of-two wrap).
  assign base    = wptr - fill[PW-1:0];
  assign raddr   = base + rd_off;
  assign rd_data = mem[raddr];
endmodule

// File: rtl/lnr_player.sv
module lnr_player
  import lnr_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          off_hook,
  input  logic          go_flash,
  input  logic          go_redial,
  input  logic          flash_done,
  input  logic          dial_idle,
  input  logic [LW-1:0] fill,
  input  logic          play_ready,
  output phase_e        phase,
  output logic [PW-1:0] rd_off,
  output logic          play_valid,
  output logic          handed
);
  logic last;

  assign last       = (LW'(rd_off) + LW'(1)) == fill;
  assign play_valid = (phase == PH_PLAY);
  assign handed     = play_valid && play_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || !off_hook) begin
      phase  <= PH_IDLE;
      rd_off <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (go_flash) begin
            phase <= PH_FLASH;
          end else if (go_redial && fill != '0) begin
            phase  <= PH_WAIT;
            rd_off <= '0;
          end
        end
        PH_FLASH: if (flash_done) phase <= PH_IDLE;
        PH_WAIT:  if (dial_idle) phase <= PH_PLAY;
        PH_PLAY: begin
          if (play_ready) begin
            if (last) phase <= PH_IDLE;
            else rd_off <= rd_off + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lnr_ctrl.sv
module lnr_ctrl
  import lnr_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int KEY_W = KEY_WIDTH,
  parameter int ENT_W = ENT_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             off_hook,
  input  logic             mode_default,
  input  logic             key_valid,
  output logic             key_ready,
  input  logic [KEY_W-1:0] key_code,
  input  logic             flash_done,
  input  logic             dial_idle,
  output logic             play_valid,
  input  logic             play_ready,
  output logic [ENT_W-1:0] play_entry,
  output logic             busy,
  output logic             tone_mode
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic             off_q;
  logic             fresh_q;
  logic             tone_q;
  logic             hook_rise;
  logic             acc;
  act_e             act;
  logic [ENT_W-1:0] new_entry;
  logic             to_tone;
  logic [LW-1:0]    fill_cnt;
  logic [PW-1:0]    rd_off;
  phase_e           phase;
  logic             handed;

  assign hook_rise = off_hook && !off_q;
  assign key_ready = off_hook && off_q && (phase == PH_IDLE);
  assign acc       = key_valid && key_ready;
  assign busy      = (phase != PH_IDLE);
  assign tone_mode = tone_q;

  lnr_key_decode #(.KEY_W(KEY_W), .ENT_W(ENT_W)) dec_i (
    .code    (key_code),
    .tone    (tone_q),
    .fresh   (fresh_q),
    .act     (act),
    .entry   (new_entry),
    .to_tone (to_tone)
  );

  lnr_ring #(.DEPTH(DEPTH), .ENT_W(ENT_W)) ring_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (acc && act == ACT_STORE),
    .wr_restart (fresh_q),
    .wr_data    (new_entry),
    .rd_off     (rd_off),
    .rd_data    (play_entry),
    .fill       (fill_cnt)
  );

  lnr_player #(.DEPTH(DEPTH)) play_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .off_hook   (off_hook),
    .go_flash   (acc && act == ACT_FLASH),
    .go_redial  (acc && act == ACT_REDIAL),
    .flash_done (flash_done),
    .dial_idle  (dial_idle),
    .fill       (fill_cnt),
    .play_ready (play_ready),
    .phase      (phase),
    .rd_off     (rd_off),
    .play_valid (play_valid),
    .handed     (handed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q   <= 1'b0;
      fresh_q <= 1'b1;
      tone_q  <= 1'b0;
    end else begin
      off_q <= off_hook;
      if (hook_rise) begin
        fresh_q <= 1'b1;
        tone_q  <= mode_default;
      end else begin
        if (acc) begin
          if (act == ACT_FLASH) fresh_q <= 1'b1;
          if (act == ACT_STORE) fresh_q <= 1'b0;
          if (to_tone) tone_q <= 1'b1;
          if (act == ACT_PULSE) tone_q <= 1'b0;
        end
        if (handed && play_entry == ENT_W'(E_MARK)) tone_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lnr_ctrl_chk.sv
module lnr_ctrl_chk #(
  parameter int DEPTH = 32,
  parameter int KEY_W = 5,
  parameter int ENT_W = 5,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             off_hook,
  input logic             key_valid,
  input logic             key_ready,
  input logic [KEY_W-1:0] key_code,
  input logic             flash_done,
  input logic             play_valid,
  input logic             play_ready,
  input logic [ENT_W-1:0] play_entry,
  input logic             busy,
  input logic [1:0]       phase,
  input logic [LW-1:0]    fill
);
  a_r1_fill_cap: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= LW'(DEPTH));

  a_r5_flash_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd1 && !flash_done && off_hook) |=> (busy && !key_ready));

  a_r5_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    key_ready |-> !busy);

  a_r6_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    play_valid |-> (busy && play_entry <= ENT_W'(13)));

  a_r9_test_keys_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && key_ready && key_code >= KEY_W'(16)) |=> $stable(fill));

  a_r10_onhook_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !off_hook |=> (!busy && !play_valid && !key_ready));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (play_valid && !play_ready && off_hook) |=> (play_valid && $stable(play_entry)));
endmodule

bind lnr_ctrl lnr_ctrl_chk #(.DEPTH(DEPTH), .KEY_W(KEY_W), .ENT_W(ENT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .off_hook   (off_hook),
  .key_valid  (key_valid),
  .key_ready  (key_ready),
  .key_code   (key_code),
  .flash_done (flash_done),
  .play_valid (play_valid),
  .play_ready (play_ready),
  .play_entry (play_entry),
  .busy       (busy),
  .phase      (phase),
  .fill       (fill_cnt)
);

// File: tb/lnr_ctrl_tb_top.sv
module lnr_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       off_hook = 1'b0;
  logic       mode_default = 1'b1;
  logic       key_valid = 1'b0;
  logic       key_ready;
  logic [4:0] key_code = '0;
  logic       flash_done = 1'b0;
  logic       dial_idle = 1'b1;
  logic       play_valid;
  logic       play_ready = 1'b0;
  logic [4:0] play_entry;
  logic       busy;
  logic       tone_mode;

  int  n_checks = 0;
  int  n_err = 0;
  bit  done = 1'b0;
  int  q[$];
  bit  mdl_fresh = 1'b1;
  bit  mdl_tone = 1'b0;

  always #4 clk = ~clk;

  lnr_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .off_hook(off_hook), .mode_default(mode_default),
    .key_valid(key_valid), .key_ready(key_ready), .key_code(key_code),
    .flash_done(flash_done), .dial_idle(dial_idle), .play_valid(play_valid),
    .play_ready(play_ready), .play_entry(play_entry), .busy(busy), .tone_mode(tone_mode)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
  endtask

  function automatic void mdl_store(input int e);
    if (mdl_fresh) begin
      q.delete();
      mdl_fresh = 1'b0;
    end
    q.push_back(e);
    if (q.size() > 32) q.delete(0);
  endfunction

  function automatic void mdl_key(input int c);
    if (c <= 9 || c == 11) mdl_store(c);
    else if (c == 10) begin
      if (mdl_tone) mdl_store(10);
      else begin mdl_store(13); mdl_tone = 1'b1; end
    end else if (c == 12) begin
      if (!mdl_fresh) mdl_store(12);
    end else if (c == 13) mdl_fresh = 1'b1;
    else if (c == 14) begin
      if (!mdl_tone) begin mdl_store(13); mdl_tone = 1'b1; end
    end else if (c == 15) mdl_tone = 1'b0;
  endfunction

  task automatic press(input int c);
    @(negedge clk);
    key_valid = 1'b1;
    key_code  = 5'(c);
    while (!key_ready) @(negedge clk);
    @(negedge clk);
    key_valid = 1'b0;
    mdl_key(c);
  endtask

  task automatic hook_cycle(input bit mode);
    @(negedge clk);
    off_hook = 1'b0;
    repeat (2) @(negedge clk);
    mode_default = mode;
    off_hook = 1'b1;
    mdl_fresh = 1'b1;
    mdl_tone = mode;
    repeat (2) @(negedge clk);
  endtask

  task automatic flash_ack();
    repeat (2) @(negedge clk);
    flash_done = 1'b1;
    @(negedge clk);
    flash_done = 1'b0;
  endtask

  // Collect playback under a fixed stall pattern and compare with the model.
  task automatic collect(input string req);
    int  got[$];
    int  k = 0;
    bit  stall = 1'b0;
    int  stall_e = 0;
    while (busy || play_valid) begin
      if (stall) chk(play_valid && play_entry == 5'(stall_e), "R12 hold", play_entry, stall_e);
      play_ready = (k % 3) != 1;
      k++;
      stall = 1'b0;
      if (play_valid) begin
        if (play_ready) got.push_back(int'(play_entry));
        else begin stall = 1'b1; stall_e = play_entry; end
      end
      @(negedge clk);
    end
    play_ready = 1'b0;
    chk(got.size() == q.size(), {req, " length"}, got.size(), q.size());
    for (int i = 0; i < q.size() && i < got.size(); i++)
      chk(got[i] == q[i], {req, " entry"}, got[i], q[i]);
    foreach (q[i]) if (q[i] == 13) mdl_tone = 1'b1;
  endtask

  task automatic redial(input string req);
    press(12);
    collect(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!key_ready, "R10 reset key_ready", key_ready, 0);
    chk(!busy && !play_valid, "R6 reset busy", busy, 0);
    chk(!tone_mode, "R4 reset tone", tone_mode, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R6: sweep of fill counts across empty, partial, full and wrapped
    for (int n = 0; n <= 40; n++) begin
      hook_cycle(1'b1);
      for (int i = 0; i < n; i++) press((i * 5 + n) % 12);
      hook_cycle(1'b1);
      redial("R1 sweep");
      chk(!busy, "R11 idle after playback", busy, 0);
    end

    // R11: empty store after a fresh number of zero length is kept from n=0 only;
    // build an explicit wait on dial_idle
    hook_cycle(1'b1);
    press(4); press(2);
    hook_cycle(1'b1);
    dial_idle = 1'b0;
    press(12);
    repeat (5) @(negedge clk);
    chk(busy && !play_valid, "R11 waits for idle", play_valid, 0);
    dial_idle = 1'b1;
    collect("R11 after idle");

    // R2: pause after a digit
    hook_cycle(1'b1);
    press(1); press(2); press(12); press(3);
    hook_cycle(1'b1);
    redial("R2 pause entry");

    // R3 R5: flash keeps, then flash plus digits replaces
    hook_cycle(1'b1);
    press(5); press(6);
    press(13);
    chk(busy && !key_ready, "R5 flash busy", busy, 1);
    key_valid = 1'b1; key_code = 5'd7;
    repeat (3) @(negedge clk);
    chk(!key_ready, "R5 keys refused in flash", key_ready, 0);
    key_valid = 1'b0;
    flash_ack();
    chk(!busy && key_ready, "R5 flash released", busy, 0);
    redial("R3 flash then redial");
    press(13); flash_ack();
    press(7); press(8);
    hook_cycle(1'b1);
    redial("R3 flash then digits");

    // R3 R4: flash straight after off-hook, twice, then redial keeps store
    hook_cycle(1'b1);
    press(13); flash_ack();
    press(13); flash_ack();
    redial("R3 repeated flash");

    // R4 R7 R8: pulse default, star and mode switches
    hook_cycle(1'b0);
    chk(tone_mode == 1'b0, "R4 pulse default", tone_mode, 0);
    press(1); press(10);
    chk(tone_mode == 1'b1, "R8 star selects tone", tone_mode, 1);
    press(10); press(15);
    chk(tone_mode == 1'b0, "R7 to pulse", tone_mode, 0);
    press(2); press(14); press(14);
    hook_cycle(1'b0);
    redial("R7 R8 marker replay");
    chk(tone_mode == mdl_tone, "R8 replay selects tone", tone_mode, mdl_tone);
    hook_cycle(1'b1);
    chk(tone_mode == 1'b1, "R4 tone default", tone_mode, 1);

    // R9: test and unused keys
    press(3); press(16); press(20); press(31); press(4);
    hook_cycle(1'b1);
    redial("R9 ignored keys");

    // R10: on-hook during playback, store retained
    dial_idle = 1'b1;
    press(12);
    while (!play_valid) @(negedge clk);
    play_ready = 1'b1;
    @(negedge clk);
    play_ready = 1'b0;
    off_hook = 1'b0;
    @(negedge clk);
    chk(!play_valid && !busy && !key_ready, "R10 abort", play_valid, 0);
    hook_cycle(1'b1);
    redial("R10 store kept");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule